// File: doc/BRIEF.md
# Link Power-Down and Lock Sequencer

This block is the timing-and-control state machine of a serial link transmitter. It decides when the link starts up and when it shuts down. It combines a power-down request with a flag that says whether the input-buffer supply is present. When either one calls for shutdown, the block holds the link off. In the off state the PLL is stopped, the termination is disconnected and the line driver is high impedance.

When the link is allowed to run, the block starts the PLL and connects the termination. It then counts a fixed number of parallel-clock cycles instead of watching an analog lock detector. During this count the driver is kept off and the two output legs are held at zero differential through the termination. When the count completes, the driver and the serializer data path are enabled.

The block also decodes a 2-bit frequency-range select. It reports the bounds of the chosen parallel-clock range and the matching serial-rate bounds. A change of the select while the link is locking or running restarts the lock count.

Top module: `link_pwr_seq`

## Requirements
- R1: After reset, state_o reads 0 (off) and pll_en_o, term_en_o, drv_en_o, drv_zero_o and data_en_o are all 0.
- R2: When pwr_on_i is low, state_o reads 0 after the next clock edge and all five enable outputs are 0, from any state.
- R3: With pwr_on_i and vin_ok_i high in the off state, state_o reads 1 (locking) after the next edge. In locking, pll_en_o=1, term_en_o=1, drv_zero_o=1, drv_en_o=0 and data_en_o=0.
- R4: The locking state lasts exactly LOCK_CYCLES clock cycles (default 16385). The block then enters state 2 (active), with pll_en_o=1, term_en_o=1, drv_en_o=1, data_en_o=1 and drv_zero_o=0.
- R5: When vin_ok_i is low, power-down is forced whatever the level of pwr_on_i: state 0 after the next edge, and the block stays there while vin_ok_i is low.
- R6: rng_sel_i is registered, and the outputs show its decode after the next edge. The parallel-clock bounds in MHz are: 0 gives 3..5, 1 gives 5..10, 2 gives 10..20 and 3 gives 20..35. The serial-rate bounds in Mbps are the MHz bounds times 20.
- R7: A change of rng_sel_i while locking or active puts the block in state 1 after the next edge, with the count restarted. Another full LOCK_CYCLES cycles must then pass before the block is active.
- R8: Power-down during locking returns the block to state 0 on the next edge and clears the count. A later start therefore takes the full LOCK_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_on_i | input | 1 | High to run the link, low for power-down |
| vin_ok_i | input | 1 | Input-buffer supply present |
| rng_sel_i | input | 2 | Frequency-range select |
| pll_en_o | output | 1 | PLL run enable |
| term_en_o | output | 1 | Connect the output termination |
| drv_en_o | output | 1 | Line driver enable |
| drv_zero_o | output | 1 | Hold the output legs at zero differential |
| data_en_o | output | 1 | Serializer data enable |
| state_o | output | 2 | 0 off, 1 locking, 2 active |
| rng_lo_mhz_o | output | 6 | Lower clock bound of the range, in MHz |
| rng_hi_mhz_o | output | 6 | Upper clock bound of the range, in MHz |
| rate_lo_mbps_o | output | 10 | Lower serial rate, in Mbps |
| rate_hi_mbps_o | output | 10 | Upper serial rate, in Mbps |

## Verification
The assertions check the following on every cycle:
- any power-down or missing input supply leads to the off state on the next edge;
- a start request from off enters locking;
- a range change while running re-enters locking;
- the active state is reached only from locking once the count is done;
- the count stays in bounds and is zero after a clear;
- the driver is never enabled together with the zero-differential hold, nor without the termination;
- the range upper bound always exceeds the lower bound.

Only the directed scenarios can show the following:
- the exact length of the lock window;
- that an aborted or restarted lock takes the full count again;
- the decoded values for each range code.

// File: rtl/link_pwr_seq_pkg.sv
package link_pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_LOCK = 2'd1,
    ST_RUN  = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/link_lock_cnt.sv
module link_lock_cnt #(
  parameter int LOCK_CYCLES = 16385
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_cnt_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/link_rng_decode.sv
module link_rng_decode #(
  parameter int MHZ_W     = 6,
  parameter int RATE_W    = 10,
  parameter int WORD_BITS = 20
) (
  input  logic [1:0]        sel_i,
  output logic [MHZ_W-1:0]  lo_mhz_o,
  output logic [MHZ_W-1:0]  hi_mhz_o,
  output logic [RATE_W-1:0] lo_rate_o,
  output logic [RATE_W-1:0] hi_rate_o
);
  always_comb begin
    unique case (sel_i)
      2'd0: begin lo_mhz_o = MHZ_W'(3);  hi_mhz_o = MHZ_W'(5);  end
      2'd1: begin lo_mhz_o = MHZ_W'(5);  hi_mhz_o = MHZ_W'(10); end
      2'd2: begin lo_mhz_o = MHZ_W'(10); hi_mhz_o = MHZ_W'(20); end
      default: begin lo_mhz_o = MHZ_W'(20); hi_mhz_o = MHZ_W'(35); end
    endcase
  end

  // serial rate = parallel clock x bits per serial word
  assign lo_rate_o = RATE_W'(lo_mhz_o) * RATE_W'(WORD_BITS);
  assign hi_rate_o = RATE_W'(hi_mhz_o) * RATE_W'(WORD_BITS);

  always_comb begin
    assert_rng_order_R6: assert (hi_mhz_o > lo_mhz_o);
  end
endmodule

// File: rtl/link_out_ctrl.sv
module link_out_ctrl
  import link_pwr_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pwr_state_e state_i,
  output logic       pll_en_o,
  output logic       term_en_o,
  output logic       drv_en_o,
  output logic       drv_zero_o,
  output logic       data_en_o
);
  always_comb begin
    pll_en_o   = 1'b0;
    term_en_o  = 1'b0;
    drv_en_o   = 1'b0;
    drv_zero_o = 1'b0;
    data_en_o  = 1'b0;
    unique case (state_i)
      ST_LOCK: begin
        pll_en_o   = 1'b1;
        term_en_o  = 1'b1;
        drv_zero_o = 1'b1;
      end
      ST_RUN: begin
        pll_en_o  = 1'b1;
        term_en_o = 1'b1;
        drv_en_o  = 1'b1;
        data_en_o = 1'b1;
      end
      default: ;
    endcase
  end

  assert_zero_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_en_o && drv_zero_o));
  assert_term_with_drv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o || drv_zero_o) |-> (term_en_o && pll_en_o));
endmodule

// File: rtl/link_pwr_seq.sv
module link_pwr_seq
  import link_pwr_seq_pkg::*;
#(
  parameter int LOCK_CYCLES = 16385,
  parameter int MHZ_W       = 6,
  parameter int RATE_W      = 10,
  parameter int WORD_BITS   = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_on_i,
  input  logic              vin_ok_i,
  input  logic [1:0]        rng_sel_i,
  output logic              pll_en_o,
  output logic              term_en_o,
  output logic              drv_en_o,
  output logic              drv_zero_o,
  output logic              data_en_o,
  output logic [1:0]        state_o,
  output logic [MHZ_W-1:0]  rng_lo_mhz_o,
  output logic [MHZ_W-1:0]  rng_hi_mhz_o,
  output logic [RATE_W-1:0] rate_lo_mbps_o,
  output logic [RATE_W-1:0] rate_hi_mbps_o
);
  pwr_state_e state_q, state_d;
  logic [1:0] rng_q;
  logic       run_eff, rng_chg, cnt_clr, cnt_inc, cnt_done;

  // missing input supply forces power-down
  assign run_eff = pwr_on_i & vin_ok_i;
  assign rng_chg = (rng_sel_i != rng_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:  if (run_eff) state_d = ST_LOCK;
      ST_LOCK: begin
        if (!run_eff)                 state_d = ST_OFF;
        else if (!rng_chg && cnt_done) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!run_eff)    state_d = ST_OFF;
        else if (rng_chg) state_d = ST_LOCK;
      end
      default: state_d = ST_OFF;
    endcase
  end

  assign cnt_clr = !(state_q == ST_LOCK && run_eff && !rng_chg);
  assign cnt_inc = !cnt_clr && !cnt_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      rng_q   <= 2'd0;
    end else begin
      state_q <= state_d;
      rng_q   <= rng_sel_i;
    end
  end

  link_lock_cnt #(.LOCK_CYCLES(LOCK_CYCLES)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .done_o (cnt_done)
  );

  link_rng_decode #(.MHZ_W(MHZ_W), .RATE_W(RATE_W), .WORD_BITS(WORD_BITS)) u_rng (
    .sel_i     (rng_q),
    .lo_mhz_o  (rng_lo_mhz_o),
    .hi_mhz_o  (rng_hi_mhz_o),
    .lo_rate_o (rate_lo_mbps_o),
    .hi_rate_o (rate_hi_mbps_o)
  );

  link_out_ctrl u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state_q),
    .pll_en_o   (pll_en_o),
    .term_en_o  (term_en_o),
    .drv_en_o   (drv_en_o),
    .drv_zero_o (drv_zero_o),
    .data_en_o  (data_en_o)
  );

  assign state_o = state_q;

  assert_pd_to_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_on_i |=> state_q == ST_OFF);
  assert_vin_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vin_ok_i |=> state_q == ST_OFF);
  assert_start_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && run_eff) |=> state_q == ST_LOCK);
  assert_rng_relock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && run_eff && rng_chg) |=> state_q == ST_LOCK);
  assert_run_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) != ST_RUN)
      |-> ($past(state_q) == ST_LOCK && $past(cnt_done)));
endmodule

// File: tb/link_pwr_seq_tb.sv
module link_pwr_seq_tb;
  localparam int N = 16385;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_on = 1'b0;
  logic vin_ok = 1'b1;
  logic [1:0] rng_sel = 2'd0;
  logic pll_en, term_en, drv_en, drv_zero, data_en;
  logic [1:0] state;
  logic [5:0] lo_mhz, hi_mhz;
  logic [9:0] lo_rate, hi_rate;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  link_pwr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_on_i(pwr_on), .vin_ok_i(vin_ok),
    .rng_sel_i(rng_sel), .pll_en_o(pll_en), .term_en_o(term_en),
    .drv_en_o(drv_en), .drv_zero_o(drv_zero), .data_en_o(data_en),
    .state_o(state), .rng_lo_mhz_o(lo_mhz), .rng_hi_mhz_o(hi_mhz),
    .rate_lo_mbps_o(lo_rate), .rate_hi_mbps_o(hi_rate)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected enables derived from state code: 0 off, 1 locking, 2 active
  task automatic chk_state(input string req, input int exp_st);
    chk(req, "state", int'(state), exp_st);
    chk(req, "pll_en", int'(pll_en), (exp_st != 0) ? 1 : 0);
    chk(req, "term_en", int'(term_en), (exp_st != 0) ? 1 : 0);
    chk(req, "drv_en", int'(drv_en), (exp_st == 2) ? 1 : 0);
    chk(req, "drv_zero", int'(drv_zero), (exp_st == 1) ? 1 : 0);
    chk(req, "data_en", int'(data_en), (exp_st == 2) ? 1 : 0);
  endtask

  // called one edge after the lock window opened
  task automatic lock_full(input string req);
    step(N - 1);
    chk_state(req, 1);
    step(1);
    chk_state(req, 2);
  endtask

  task automatic t_reset_r1;
    step(3);
    rst_ni = 1'b1;
    step(1);
    chk_state("R1", 0);
    step(4);
    chk_state("R1", 0);
  endtask

  task automatic t_range_r6;
    int lo_t[4] = '{3, 5, 10, 20};
    int hi_t[4] = '{5, 10, 20, 35};
    for (int k = 0; k < 4; k++) begin
      rng_sel = 2'(k);
      step(1);
      chk("R6", "lo_mhz", int'(lo_mhz), lo_t[k]);
      chk("R6", "hi_mhz", int'(hi_mhz), hi_t[k]);
      chk("R6", "lo_rate", int'(lo_rate), lo_t[k] * 20);
      chk("R6", "hi_rate", int'(hi_rate), hi_t[k] * 20);
    end
  endtask

  task automatic t_lock_r3_r4;
    rng_sel = 2'd1;
    step(1);
    pwr_on = 1'b1;
    step(1);
    chk_state("R3", 1);
    lock_full("R4");
  endtask

  task automatic t_pd_run_r2;
    pwr_on = 1'b0;
    step(1);
    chk_state("R2", 0);
    step(3);
    chk_state("R2", 0);
  endtask

  task automatic t_pd_lock_r8;
    pwr_on = 1'b1;
    step(1);
    chk_state("R8", 1);
    step(200);
    chk_state("R8", 1);
    pwr_on = 1'b0;
    step(1);
    chk_state("R8", 0);
    pwr_on = 1'b1;
    step(1);
    chk_state("R8", 1);
    lock_full("R8");
  endtask

  task automatic t_rng_run_r7;
    rng_sel = 2'd2;
    step(1);
    chk_state("R7", 1);
    chk("R7", "lo_mhz", int'(lo_mhz), 10);
    lock_full("R7");
  endtask

  task automatic t_rng_lock_r7;
    rng_sel = 2'd3;
    step(1);
    chk_state("R7", 1);
    step(300);
    rng_sel = 2'd0;
    step(1);
    chk_state("R7", 1);
    lock_full("R7");
  endtask

  task automatic t_vin_r5;
    vin_ok = 1'b0;
    step(1);
    chk_state("R5", 0);
    step(10);
    chk_state("R5", 0);
    vin_ok = 1'b1;
    step(1);
    chk_state("R5", 1);
    step(20);
    vin_ok = 1'b0;
    step(1);
    chk_state("R5", 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_range_r6();
    t_lock_r3_r4();
    t_pd_run_r2();
    t_pd_lock_r8();
    t_rng_run_r7();
    t_rng_lock_r7();
    t_vin_r5();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule